// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

A synthesizable model of a pipelined synchronous burst SRAM with a small on-chip array of 36-bit words, each word split into four 9-bit byte lanes. A new address is taken in by either of two active-low address strobes. One is meant for a processor and one for a cache or memory controller. The chip-select state is sampled only at that address load. A 2-bit burst counter, seeded from the two low address bits, then steps the effective address through a 4-word block each time the advance input is held low.

Writes are either global (all lanes) or per byte, under a byte-write enable and four per-lane selects. They are committed on the clock edge at which they are sampled. Reads are pipelined: the array is read on the edge after the address was set up, and the data stays registered at the output. Instead of a tri-state pad, the block has a separate data output and an output-enable flag. The flag combines the asynchronous output-enable input with the validity of the read pipeline.

Top module: `burst_sram_core`

## Requirements
- R1: The registered address and the select state are loaded on a rising edge only when the controller strobe `ctrl_strb_ni` is low, or when the processor strobe `proc_strb_ni` is low while `cs1_ni` is low. On other edges both are kept.
- R2: The processor strobe is ignored while `cs1_ni` is high, so it then loads nothing. The controller strobe still loads when it is low, whatever `cs1_ni` is. When both strobes are accepted in one cycle, the processor strobe is the one honoured and the address on `addr_i` is captured.
- R3: The device is selected when, at a load edge, `cs1_ni` is low, `cs2_i` is high and `cs3_ni` is low. Chip-enable values between loads have no effect. While the device is deselected, no write is committed and `rdata_oe_o` stays low.
- R4: A load seeds the 2-bit burst counter with `addr_i[1:0]`. On a non-load edge with `adv_ni` low, the counter steps linearly and wraps modulo 4. The upper address bits stay fixed.
- R5: On an edge with both strobes high and `adv_ni` high, the effective address is held, so a read repeats the same word.
- R6: With `gw_ni` low, all four lanes are written, whatever `bwe_ni` and `bw_ni` are.
- R7: With `gw_ni` high and `bwe_ni` low, lane b (data bits `[9*b+8:9*b]`) is written when `bw_ni[b]` is low. With both `gw_ni` and `bwe_ni` high, nothing is written.
- R8: A write is committed on a non-load edge while the device is selected. It stores `wdata_i` at the current effective address on that same edge. An edge that loads an address writes nothing.
- R9: On an edge where the device is selected and no lane is written, the array is read at the effective address held before that edge. The word appears on `rdata_o` just after the edge, and the read is marked valid. Reset clears `rdata_o` and the read-valid state.
- R10: `rdata_oe_o` is high only when `oe_ni` is low (this path is combinational) and the last edge produced a valid read. As a result it stays low during the first clock after a load that selects the device out of a deselected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, captured on a load |
| proc_strb_ni | input | 1 | Processor address strobe, active low, gated by cs1_ni |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| cs1_ni | input | 1 | Chip enable 1, active low |
| cs2_i | input | 1 | Chip enable 2, active high |
| cs3_ni | input | 1 | Chip enable 3, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | LANES | Per-lane byte selects, active low |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rdata_oe_o | output | 1 | High when rdata_o is being driven |

## Verification
An address load takes effect on the edge at which it is sampled, and a write is committed on the edge at which it is sampled. A read word appears on `rdata_o`, with `rdata_oe_o` set, one edge after its effective address was established. The enable path from `oe_ni` to `rdata_oe_o` is combinational and needs no edge. The bench changes inputs well away from the rising edge and updates its reference model right at that edge, using the same input values. It compares `rdata_oe_o` and, where that flag is expected, `rdata_o` one time unit after each edge. The asynchronous enable is checked one time unit after `oe_ni` moves, with no clock in between.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_W = 2;

  function automatic logic chip_sel(input logic cs1_n, input logic cs2, input logic cs3_n);
    return !cs1_n && cs2 && !cs3_n;
  endfunction
endpackage

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              cs1_ni,
  input  logic              cs2_i,
  input  logic              cs3_ni,
  input  logic              adv_ni,
  output logic              load_o,
  output logic              sel_o,
  output logic [ADDR_W-1:0] eff_addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              proc_load, ctrl_load;
  logic [HI_W-1:0]   base_q;
  logic [BURST_W-1:0] cnt_q;
  logic              sel_q;

  // processor strobe wins; it is dropped while cs1 is inactive
  assign proc_load = !proc_strb_ni && !cs1_ni;
  assign ctrl_load = !ctrl_strb_ni && !proc_load;
  assign load_o    = proc_load || ctrl_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (load_o) begin
      base_q <= addr_i[ADDR_W-1:BURST_W];
      cnt_q  <= addr_i[BURST_W-1:0];
      sel_q  <= chip_sel(cs1_ni, cs2_i, cs3_ni);
    end else if (!adv_ni) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sel_o      = sel_q;
  assign eff_addr_o = {base_q, cnt_q};
endmodule

// File: rtl/byte_write_decode.sv
module byte_write_decode #(
  parameter int LANES = 4
) (
  input  logic             en_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] we_o
);
  always_comb begin
    if (!en_i)        we_o = '0;
    else if (!gw_ni)  we_o = '1;
    else if (!bwe_ni) we_o = ~bw_ni;
    else              we_o = '0;
  end
endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    proc_strb_ni,
  input  logic                    ctrl_strb_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs3_ni,
  input  logic                    adv_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  logic              load, sel;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd_en, rd_vld_q;

  burst_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .addr_i, .proc_strb_ni, .ctrl_strb_ni,
    .cs1_ni, .cs2_i, .cs3_ni, .adv_ni,
    .load_o(load), .sel_o(sel), .eff_addr_o(eff_addr)
  );

  // writes land only on non-load edges of a selected device
  byte_write_decode #(.LANES(LANES)) u_bw (
    .en_i(sel && !load), .gw_ni, .bwe_ni, .bw_ni, .we_o(lane_we)
  );

  assign rd_en = sel && !(|lane_we);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    lane_ram #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_ram (
      .clk_i, .rst_ni,
      .addr_i (eff_addr),
      .we_i   (lane_we[b]),
      .re_i   (rd_en),
      .wdata_i(wdata_i[b*LANE_W +: LANE_W]),
      .rdata_o(rdata_o[b*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_en;
  end

  assign rdata_oe_o = !oe_ni && rd_vld_q;
endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_strb_ni,
  input logic              ctrl_strb_ni,
  input logic              cs1_ni,
  input logic              adv_ni,
  input logic              oe_ni,
  input logic              sel,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              rdata_oe_o
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!proc_strb_ni && !cs1_ni) || !ctrl_strb_ni) |=> eff_addr == $past(addr_i)); // R1

  AST_PROC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strb_ni && cs1_ni && ctrl_strb_ni) |=>
      (eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])) && $stable(sel)); // R2

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_strb_ni && ctrl_strb_ni) |=> $stable(sel)); // R3

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_strb_ni && ctrl_strb_ni && !adv_ni) |=>
      (eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1) &&
      (eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2]))); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_strb_ni && ctrl_strb_ni && adv_ni) |=> $stable(eff_addr)); // R5

  AST_OE_FIRST_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel) |-> !rdata_oe_o); // R10

  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdata_oe_o); // R10
endmodule

bind burst_sram_core burst_sram_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .proc_strb_ni, .ctrl_strb_ni, .cs1_ni,
  .adv_ni, .oe_ni, .sel(sel), .eff_addr(eff_addr), .rdata_oe_o
);

// File: tb/burst_sram_core_bench.sv
module burst_sram_core_bench;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic p_n = 1'b1, c_n = 1'b1, cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R9";
  bit done = 1'b0;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_cnt  = '0;
  logic          m_sel  = 1'b0;
  logic          m_vld  = 1'b0;
  logic [DW-1:0] m_rd   = '0;

  always #5 clk = ~clk;

  burst_sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_burst_sram_core (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .proc_strb_ni(p_n), .ctrl_strb_ni(c_n),
    .cs1_ni(cs1_n), .cs2_i(cs2), .cs3_ni(cs3_n), .adv_ni(adv_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  function automatic logic [NL-1:0] exp_mask(logic g_n, logic be_n, logic [NL-1:0] b_n);
    if (!g_n)  return '1;
    if (!be_n) return ~b_n;
    return '0;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model update at the edge, compare just after it
  task automatic tick();
    logic pl, ld, wr;
    logic [NL-1:0] mk;
    logic [AW-1:0] ea;
    @(posedge clk);
    pl = !p_n && !cs1_n;
    ld = pl || !c_n;
    ea = {m_base, m_cnt};
    mk = (m_sel && !ld) ? exp_mask(gw_n, bwe_n, bw_n) : '0;
    wr = |mk;
    for (int b = 0; b < NL; b++)
      if (mk[b]) m_mem[ea][b*LW +: LW] = wdata[b*LW +: LW];
    if (m_sel && !wr) m_rd = m_mem[ea];
    m_vld = m_sel && !wr;
    if (ld) begin
      m_base = addr[AW-1:2];
      m_cnt  = addr[1:0];
      m_sel  = !cs1_n && cs2 && !cs3_n;
    end else if (!adv_n) m_cnt = m_cnt + 2'd1;
    #1;
    chk({cur_tag, " oe"}, {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, !oe_n && m_vld});
    if (!oe_n && m_vld) chk({cur_tag, " data"}, rdata, m_rd);
  endtask

  task automatic idle();
    p_n = 1'b1; c_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
  endtask

  task automatic load(logic use_proc, logic [AW-1:0] a);
    idle();
    addr = a;
    if (use_proc) p_n = 1'b0; else c_n = 1'b0;
    tick();
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    #23;
    // R9: reset state
    chk("R9 reset data", rdata, '0);
    chk("R9 reset oe", {{(DW-1){1'b0}}, rdata_oe}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: fill the array with global-write bursts
    cur_tag = "R6";
    for (int blk = 0; blk < DEPTH / 4; blk++) begin
      load(1'b0, AW'(blk * 4));
      for (int k = 0; k < 4; k++) begin
        gw_n = 1'b0; bwe_n = 1'b1; bw_n = 4'($urandom); adv_n = 1'b0;
        wdata = {$urandom, 4'($urandom)};
        tick();
      end
      idle();
    end
    // read back a block with a burst
    load(1'b1, 6'd8);
    adv_n = 1'b0;
    for (int k = 0; k < 5; k++) tick();

    // R4: seed from low bits and wrap modulo 4
    cur_tag = "R4";
    load(1'b0, 6'd22);
    adv_n = 1'b0;
    for (int k = 0; k < 6; k++) tick();

    // R5: hold repeats the same word
    cur_tag = "R5";
    load(1'b1, 6'd37);
    for (int k = 0; k < 4; k++) tick();

    // R7: byte-masked writes, then read
    cur_tag = "R7";
    load(1'b0, 6'd12);
    for (int m = 0; m < 16; m++) begin
      gw_n = 1'b1; bwe_n = 1'b0; bw_n = 4'(m); wdata = {$urandom, 4'($urandom)};
      tick();
      idle(); tick();
    end
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '0; wdata = '1;   // no write: bwe high
    tick();
    idle(); tick();

    // R2: processor strobe ignored with cs1 high; controller strobe still loads
    cur_tag = "R2";
    load(1'b0, 6'd40);
    tick();
    cs1_n = 1'b1; addr = 6'd50; p_n = 1'b0; tick();
    idle(); cs1_n = 1'b0; tick();
    addr = 6'd51; p_n = 1'b0; c_n = 1'b0; cs1_n = 1'b1; tick();
    idle(); cs1_n = 1'b0; tick(); tick();
    addr = 6'd53; p_n = 1'b0; c_n = 1'b0; tick();
    idle(); tick();

    // R3: chip enables between loads ignored; deselect blocks writes and output
    cur_tag = "R3";
    load(1'b0, 6'd44);
    cs2 = 1'b0; cs3_n = 1'b1; tick(); tick();
    cs2 = 1'b1; cs3_n = 1'b0;
    addr = 6'd45; c_n = 1'b0; cs2 = 1'b0; tick();
    idle(); cs2 = 1'b1;
    gw_n = 1'b0; wdata = '1; tick();
    idle(); tick();
    addr = 6'd45; c_n = 1'b0; cs3_n = 1'b1; tick();
    idle(); cs3_n = 1'b0; tick();

    // R10: first clock after selecting from deselected is masked
    cur_tag = "R10";
    load(1'b0, 6'd30);
    tick();
    oe_n = 1'b1; #1;
    chk("R10 async oe high", {{(DW-1){1'b0}}, rdata_oe}, '0);
    oe_n = 1'b0; #1;
    chk("R10 async oe low", {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, m_vld});

    // R8: load edge writes nothing; write goes to current address
    cur_tag = "R8";
    addr = 6'd60; c_n = 1'b0; gw_n = 1'b0; wdata = {$urandom, 4'($urandom)}; tick();
    idle(); tick();
    gw_n = 1'b0; wdata = {$urandom, 4'($urandom)}; tick();
    idle(); tick();

    // R1 and R9: constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      cur_tag = (i % 2 == 0) ? "R1" : "R9";
      addr  = AW'($urandom);
      p_n   = ($urandom % 5) != 0;
      c_n   = ($urandom % 5) != 0;
      cs1_n = ($urandom % 6) == 0;
      cs2   = ($urandom % 8) != 0;
      cs3_n = ($urandom % 8) == 0;
      adv_n = ($urandom % 2) == 0;
      gw_n  = ($urandom % 7) != 0;
      bwe_n = ($urandom % 3) != 0;
      bw_n  = 4'($urandom);
      oe_n  = ($urandom % 7) == 0;
      wdata = {$urandom, 4'($urandom)};
      tick();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule